// File: doc/BRIEF.md
# Run-Time Width-Selectable Timer Counter

This block is a timer/counter that advances once for every clock cycle in which an external prescaled `tick` input is high. A control bit selects its width at run time. In 8-bit mode the counter is one byte wide and has two independent compare channels, A and B. In 16-bit mode the counter spans two bytes and the two compare bytes merge into one 16-bit compare value: compare A supplies the low byte and compare B the high byte. A second control bit picks the counting sequence. In free-running mode the counter wraps at its maximum. In clear-on-match mode the compare value becomes the top of the count.

Software reaches the block through an 8-bit register bus with registered read data. In 16-bit mode, multi-byte values are transferred through one shared temporary byte so that each 16-bit transfer is atomic. Reading the low counter byte captures the high byte. Writing a high byte (counter or compare B) only stages it, and the following low-byte write commits both bytes in one cycle. The live counter value and the capture-related control bits are presented on output ports so that a capture unit can use them. Overflow and compare events set sticky flags. Software clears a flag by writing a one to it.

Register addresses: 0 control, 1 counter low, 2 counter high, 3 compare A, 4 compare B, 5 flags. Control bits: 7 width (1 = 16-bit), 6 capture enable, 5 capture filter enable, 4 capture edge, 3 alternate capture source, 2:1 reserved, 0 clear-on-match. Flag bits: 0 overflow, 1 compare A, 2 compare B.

Top module: `tmr_wide_counter`

## Requirements
- R1: After a synchronous reset, the counter, all flags, the control register and both compare registers are zero.
- R2: The control register holds what was written to bits 7:3 and bit 0, and bits 2:1 always read back as zero (writing 0xFF reads back 0xF9).
- R3: In 8-bit free-running mode the counter advances by one on each clock edge where `tick` is high, holds its value when `tick` is low, and wraps from 0xFF to 0x00 while setting the overflow flag (bit 0).
- R4: In 16-bit free-running mode the count carries from 0x00FF to 0x0100, and it wraps from 0xFFFF to 0x0000 while setting the overflow flag.
- R5: In clear-on-match mode (control bit 0 = 1), a tick taken while the counter equals the top (compare A in 8-bit mode, {compare B, compare A} in 16-bit mode) loads zero and sets the compare A flag (bit 1).
- R6: In 8-bit mode, a tick taken while the counter equals compare A sets flag bit 1, and a tick taken while the counter equals compare B sets flag bit 2.
- R7: In 16-bit mode, reading the counter low byte captures the high byte at that moment, and the next read of the counter high byte returns the captured byte even if the counter has since moved on.
- R8: In 16-bit mode, a counter high-byte write leaves the counter unchanged, and the next counter low-byte write loads both bytes together.
- R9: In 16-bit mode, a compare B write is staged without changing compare B, and the next compare A write updates both compare bytes together.
- R10: Flags are sticky. Writing a one to a flag bit clears it, and writing zero has no effect.
- R11: A bus write to the counter low byte takes priority over a simultaneous tick.
- R12: In 8-bit mode, the counter high byte stays zero, reads as zero, and ignores writes.
- R13: `cap_cfg` presents control bits 6:3, with bit 6 as its most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable, one count per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid one cycle after `bus_rd` |
| count_value | output | 16 | Live counter value for a capture unit |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmpa_flag | output | 1 | Sticky compare A / combined compare flag |
| cmpb_flag | output | 1 | Sticky compare B flag (8-bit mode) |
| cap_cfg | output | 4 | Capture enable, filter, edge and source control bits |

## Verification
Read data appears on `bus_rdata` in the cycle after the edge that samples `bus_rd`. The scoreboard monitor therefore pops an expected byte one clock after each read strobe and compares it at the falling edge. The counter, the flags and every register write take effect on the rising edge that samples the tick or the write strobe. The bench drives inputs on falling edges and checks `count_value`, the flags and `cap_cfg` at the falling edge right after the last strobe. The clock-level properties on counting, wrapping and clearing each look exactly one cycle ahead of their trigger.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] RA_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] RA_CMP_A  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_CMP_B  = 3'd4;
  localparam logic [ADDR_W-1:0] RA_FLAGS  = 3'd5;

  // control bit positions
  localparam int CB_WIDE  = 7;
  localparam int CB_CAPEN = 6;
  localparam int CB_ALT   = 3;
  localparam int CB_CTC   = 0;
  localparam int CAP_W    = CB_CAPEN - CB_ALT + 1;

  // flag bit positions
  localparam int FLAG_N  = 3;
  localparam int FB_OVF  = 0;
  localparam int FB_CMPA = 1;
  localparam int FB_CMPB = 2;
endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [2*DW-1:0]   cnt_q,
  input  logic [FLAG_N-1:0] flags_q,
  output logic [DW-1:0]     ctrl_q,
  output logic [DW-1:0]     cmp_a_q,
  output logic [DW-1:0]     cmp_b_q,
  output logic [DW-1:0]     rdata_q,
  output logic              load_en,
  output logic [2*DW-1:0]   load_val,
  output logic [FLAG_N-1:0] flag_clr
);
  localparam int CW = 2 * DW;
  localparam logic [DW-1:0] CTRL_WMASK = ~{{(DW-3){1'b0}}, 3'b110};

  logic [DW-1:0] temp_q;
  logic          wide;
  logic          wr_ctrl, wr_cnt_hi, wr_cmp_a, wr_cmp_b, wr_flags, rd_cnt_lo;

  assign wide      = ctrl_q[CB_WIDE];
  assign wr_ctrl   = bus_wr && (bus_addr == RA_CTRL);
  assign wr_cnt_hi = bus_wr && (bus_addr == RA_CNT_HI);
  assign wr_cmp_a  = bus_wr && (bus_addr == RA_CMP_A);
  assign wr_cmp_b  = bus_wr && (bus_addr == RA_CMP_B);
  assign wr_flags  = bus_wr && (bus_addr == RA_FLAGS);
  assign rd_cnt_lo = bus_rd && (bus_addr == RA_CNT_LO);

  // counter load strobe and value go straight to the core register
  always_comb begin
    load_en  = bus_wr && (bus_addr == RA_CNT_LO);
    load_val = wide ? {temp_q, bus_wdata} : {{DW{1'b0}}, bus_wdata};
    flag_clr = wr_flags ? bus_wdata[FLAG_N-1:0] : '0;
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_WMASK;
      if (wr_cmp_a) begin
        cmp_a_q <= bus_wdata;
        if (wide) cmp_b_q <= temp_q;
      end
      if (wr_cmp_b && !wide) cmp_b_q <= bus_wdata;
    end
  end

  // shared temporary byte for atomic 16-bit transfers
  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q <= '0;
    end else if (wide && (wr_cnt_hi || wr_cmp_b)) begin
      temp_q <= bus_wdata;
    end else if (wide && rd_cnt_lo) begin
      temp_q <= cnt_q[CW-1:DW];
    end
  end

  // registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        RA_CTRL:   rdata_q <= ctrl_q;
        RA_CNT_LO: rdata_q <= cnt_q[DW-1:0];
        RA_CNT_HI: rdata_q <= wide ? temp_q : '0;
        RA_CMP_A:  rdata_q <= cmp_a_q;
        RA_CMP_B:  rdata_q <= cmp_b_q;
        RA_FLAGS:  rdata_q <= {{(DW-FLAG_N){1'b0}}, flags_q};
        default:   rdata_q <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
  import tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wide,
  input  logic              ctc,
  input  logic [DW-1:0]     cmp_a,
  input  logic [DW-1:0]     cmp_b,
  input  logic              load_en,
  input  logic [2*DW-1:0]   load_val,
  input  logic [FLAG_N-1:0] flag_clr,
  output logic [2*DW-1:0]   cnt_q,
  output logic [FLAG_N-1:0] flags_q
);
  localparam int CW = 2 * DW;

  logic [CW-1:0]     max_v, top_v, cmp_wide, nxt;
  logic              at_max, at_top;
  logic [FLAG_N-1:0] flag_set;

  always_comb begin
    cmp_wide = {cmp_b, cmp_a};
    max_v    = wide ? {CW{1'b1}} : {{DW{1'b0}}, {DW{1'b1}}};
    top_v    = ctc ? (wide ? cmp_wide : {{DW{1'b0}}, cmp_a}) : max_v;
    at_max   = (cnt_q == max_v);
    at_top   = (cnt_q == top_v);
    nxt      = (at_max || at_top) ? '0 : cnt_q + CW'(1);
    if (!wide) nxt[CW-1:DW] = '0;

    flag_set = '0;
    if (tick && !load_en) begin
      flag_set[FB_OVF]  = at_max;
      flag_set[FB_CMPA] = wide ? (cnt_q == cmp_wide) : (cnt_q[DW-1:0] == cmp_a);
      flag_set[FB_CMPB] = !wide && (cnt_q[DW-1:0] == cmp_b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_en) begin
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= nxt;
    end else if (!wide) begin
      cnt_q[CW-1:DW] <= '0;
    end
  end

  // one sticky bit per event; set wins over a same-cycle clear
  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (rst)              f_q <= 1'b0;
      else if (flag_set[g]) f_q <= 1'b1;
      else if (flag_clr[g]) f_q <= 1'b0;
    end
    assign flags_q[g] = f_q;
  end
endmodule

// File: rtl/tmr_wide_counter.sv
`timescale 1ns/1ps
module tmr_wide_counter
  import tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [2*DW-1:0]   count_value,
  output logic              ovf_flag,
  output logic              cmpa_flag,
  output logic              cmpb_flag,
  output logic [CAP_W-1:0]  cap_cfg
);
  localparam int CW = 2 * DW;

  logic [DW-1:0]     ctrl_q, cmp_a_q, cmp_b_q;
  logic [CW-1:0]     cnt_q, load_val;
  logic [FLAG_N-1:0] flags_q, flag_clr;
  logic              load_en;

  tmr_regs #(.DW(DW)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cnt_q    (cnt_q),
    .flags_q  (flags_q),
    .ctrl_q   (ctrl_q),
    .cmp_a_q  (cmp_a_q),
    .cmp_b_q  (cmp_b_q),
    .rdata_q  (bus_rdata),
    .load_en  (load_en),
    .load_val (load_val),
    .flag_clr (flag_clr)
  );

  tmr_core #(.DW(DW)) core_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wide    (ctrl_q[CB_WIDE]),
    .ctc     (ctrl_q[CB_CTC]),
    .cmp_a   (cmp_a_q),
    .cmp_b   (cmp_b_q),
    .load_en (load_en),
    .load_val(load_val),
    .flag_clr(flag_clr),
    .cnt_q   (cnt_q),
    .flags_q (flags_q)
  );

  assign count_value = cnt_q;
  assign ovf_flag    = flags_q[FB_OVF];
  assign cmpa_flag   = flags_q[FB_CMPA];
  assign cmpb_flag   = flags_q[FB_CMPB];
  assign cap_cfg     = ctrl_q[CB_CAPEN:CB_ALT];
endmodule

// File: rtl/tmr_wide_counter_chk.sv
`timescale 1ns/1ps
module tmr_wide_counter_chk
  import tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [2*DW-1:0]   count_value,
  input logic              ovf_flag,
  input logic              cmpa_flag,
  input logic [DW-1:0]     ctrl_q,
  input logic [DW-1:0]     cmp_a_q
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt_inc;
  assign cnt_inc = count_value + CW'(1);

  // R2: reserved control bits read back as zero
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == RA_CTRL) |=> (bus_rdata[2:1] == 2'b00));

  // R3: no tick and no bus write leaves the counter alone
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !bus_wr) |=> $stable(count_value));

  // R4: 16-bit free-running step below the maximum
  p_step16_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !bus_wr && ctrl_q[CB_WIDE] && !ctrl_q[CB_CTC] && count_value != {CW{1'b1}})
    |=> (count_value == $past(cnt_inc)));

  // R4: wrap from all ones sets overflow
  p_wrap_ovf_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !bus_wr && count_value == {CW{1'b1}}) |=> (count_value == '0 && ovf_flag));

  // R5: 8-bit clear-on-match reaches zero with the compare flag set
  p_ctc_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !bus_wr && ctrl_q[CB_CTC] && !ctrl_q[CB_WIDE] && count_value[DW-1:0] == cmp_a_q)
    |=> (count_value == '0 && cmpa_flag));

  // R10: overflow flag stays set unless a one is written to it
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(bus_wr && bus_addr == RA_FLAGS && bus_wdata[FB_OVF])) |=> ovf_flag);

  // R12: high byte is zero in 8-bit mode
  p_hi_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CB_WIDE] && !bus_wr) |=> (count_value[CW-1:DW] == '0));
endmodule

bind tmr_wide_counter tmr_wide_counter_chk #(.DW(DW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .count_value(count_value),
  .ovf_flag   (ovf_flag),
  .cmpa_flag  (cmpa_flag),
  .ctrl_q     (ctrl_q),
  .cmp_a_q    (cmp_a_q)
);

// File: tb/tmr_wide_counter_tb_top.sv
`timescale 1ns/1ps
module tmr_wide_counter_tb_top;
  import tmr_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] count_value;
  logic        ovf_flag, cmpa_flag, cmpb_flag;
  logic [3:0]  cap_cfg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic rd_d = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  tmr_wide_counter dut_i (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count_value(count_value), .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag),
    .cmpb_flag(cmpb_flag), .cap_cfg(cap_cfg)
  );

  // monitor: read data is due one edge after the strobe
  always @(posedge clk) rd_d <= bus_rd;

  always @(negedge clk) begin
    if (rd_d) begin
      logic [7:0] e;
      string t;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: unexpected read data %h, expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 count", count_value, 0);
    chk("R1 flags", {ovf_flag, cmpa_flag, cmpb_flag}, 0);
    rd(RA_CTRL, 8'h00, "R1 ctrl");
    rd(RA_CMP_A, 8'h00, "R1 cmpa");
    rd(RA_CMP_B, 8'h00, "R1 cmpb");

    // R2 control layout, R13 capture bits
    wr(RA_CTRL, 8'hFF);
    rd(RA_CTRL, 8'hF9, "R2 reserved");
    chk("R13 cap_cfg all", cap_cfg, 4'hF);
    wr(RA_CTRL, 8'h00);
    rd(RA_CTRL, 8'h00, "R2 cleared");

    // R3 8-bit free running and wrap
    wr(RA_CNT_LO, 8'hFD);
    ticks(2);
    chk("R3 count FF", count_value, 16'h00FF);
    chk("R3 no ovf yet", ovf_flag, 0);
    ticks(1);
    chk("R3 wrap", count_value, 16'h0000);
    chk("R3 ovf", ovf_flag, 1);
    repeat (3) @(negedge clk);
    chk("R3 hold", count_value, 16'h0000);

    // R10 write-one-to-clear
    wr(RA_FLAGS, 8'h00);
    rd(RA_FLAGS, 8'h01, "R10 zero write");
    wr(RA_FLAGS, 8'h01);
    rd(RA_FLAGS, 8'h00, "R10 cleared");

    // R6 8-bit compare channels
    wr(RA_CMP_A, 8'h05);
    wr(RA_CMP_B, 8'h07);
    wr(RA_CNT_LO, 8'h03);
    ticks(3);
    chk("R6 count", count_value, 16'h0006);
    chk("R6 cmpa", {cmpa_flag, cmpb_flag}, 2'b10);
    ticks(2);
    chk("R6 cmpb", cmpb_flag, 1);
    rd(RA_FLAGS, 8'h06, "R6 flags");
    wr(RA_FLAGS, 8'h07);

    // R5 8-bit clear on match
    wr(RA_CTRL, 8'h01);
    wr(RA_CNT_LO, 8'h04);
    ticks(1);
    chk("R5 at top", count_value, 16'h0005);
    chk("R5 no flag", cmpa_flag, 0);
    ticks(1);
    chk("R5 cleared", count_value, 16'h0000);
    chk("R5 flag", cmpa_flag, 1);

    // R11 load beats tick
    @(negedge clk);
    tick = 1'b1; bus_wr = 1'b1; bus_addr = RA_CNT_LO; bus_wdata = 8'h40;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    chk("R11 load priority", count_value, 16'h0040);

    // R12 8-bit high byte
    wr(RA_CTRL, 8'h00);
    wr(RA_CNT_HI, 8'h12);
    rd(RA_CNT_HI, 8'h00, "R12 hi read");
    chk("R12 hi ignored", count_value, 16'h0040);

    // R4 16-bit counting
    wr(RA_FLAGS, 8'h07);
    wr(RA_CTRL, 8'h80);
    wr(RA_CNT_HI, 8'h00);
    wr(RA_CNT_LO, 8'hFF);
    ticks(1);
    chk("R4 carry", count_value, 16'h0100);
    wr(RA_CNT_HI, 8'hFF);
    wr(RA_CNT_LO, 8'hFE);
    ticks(2);
    chk("R4 wrap", count_value, 16'h0000);
    chk("R4 ovf", ovf_flag, 1);

    // R8 staged high write
    wr(RA_CNT_HI, 8'h34);
    chk("R8 staged", count_value, 16'h0000);
    wr(RA_CNT_LO, 8'h56);
    chk("R8 commit", count_value, 16'h3456);

    // R7 atomic read
    wr(RA_CNT_HI, 8'h34);
    wr(RA_CNT_LO, 8'hFF);
    rd(RA_CNT_LO, 8'hFF, "R7 low");
    ticks(1);
    rd(RA_CNT_HI, 8'h34, "R7 latched high");
    rd(RA_CNT_LO, 8'h00, "R7 low again");
    rd(RA_CNT_HI, 8'h35, "R7 new high");

    // R9 combined compare write
    wr(RA_CMP_B, 8'h02);
    rd(RA_CMP_B, 8'h07, "R9 staged");
    wr(RA_CMP_A, 8'h10);
    rd(RA_CMP_B, 8'h02, "R9 commit high");
    rd(RA_CMP_A, 8'h10, "R9 commit low");

    // R5 16-bit clear on match
    wr(RA_FLAGS, 8'h07);
    wr(RA_CTRL, 8'h81);
    wr(RA_CNT_HI, 8'h02);
    wr(RA_CNT_LO, 8'h0F);
    ticks(1);
    chk("R5 wide at top", count_value, 16'h0210);
    chk("R5 wide no flag", cmpa_flag, 0);
    ticks(1);
    chk("R5 wide cleared", count_value, 16'h0000);
    chk("R5 wide flags", {ovf_flag, cmpa_flag}, 2'b01);

    // R13 capture bits mapping
    wr(RA_CTRL, 8'h50);
    chk("R13 cap_cfg", cap_cfg, 4'hA);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: %0d reads pending, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule